// File: doc/BRIEF.md
# Frame Error Interrupt Controller with Error Code Capture

This block gathers six frame-level error events reported by a CAN protocol engine into a sticky status register. A per-condition enable register decides which of those events may raise a single summary interrupt flag. That flag drives the interrupt line toward the processor. A companion capture register records a description of the first bus error: its kind, whether the node was sending or receiving, and the frame segment in which it struck. Later bus errors cannot overwrite that record until software reads it.

Software sees four byte-wide registers on a simple strobe-based read/write port. The protocol engine supplies one-cycle event pulses and an error descriptor that is valid together with the bus error pulse. The interrupt flag is cleared in two steps. Software first clears the individual status bits that caused it, then writes 1 to the flag itself. The bus error status bit cannot be written. It is cleared as a side effect of reading the capture register, and the same read re-arms the capture.

Top module: `frame_err_irq`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `irq_o` is low.
- R2: A pulse on `cond_evt_i[i]` sets status bit i (address 0) on the next clock. The bit layout is: 0 pre-buffer overflow, 1 arbitration lost, 2 error warning, 3 bus error, 4 error passive, 5 bus off. The enable register at address 1 is read/write on bits 5:0 with the same layout.
- R3: An event on a condition whose enable bit is set sets the summary flag on the next clock. The summary flag is bit 4 of address 2, and `irq_o` equals it. An event on a disabled condition sets only its status bit.
- R4: Writing 1 to bit 4 of address 2 clears the summary flag only if no status bit with its enable set is 1 at the time of the write. Otherwise the write is ignored.
- R5: Writing 1 to status bits 0, 1, 2, 4 or 5 clears them. A write to bit 3 has no effect.
- R6: A read strobe (`reg_rd_i`) at address 3 clears status bit 3.
- R7: Address 3 reads the captured descriptor taken from `err_code_i` on a bus error while capture is armed. Bits 7:6 hold the error kind (00 bit, 01 form, 10 stuff, 11 other). Bit 5 holds the direction. Bits 4:0 hold the frame segment code. Writes to address 3 are ignored.
- R8: Once a descriptor is captured, capture stays locked. Further bus errors still set status bit 3 but leave the descriptor unchanged until address 3 is read.
- R9: When a hardware event and a software clear hit the same status bit, or the summary flag, in the same cycle, the bit ends up set.
- R10: A read of address 3 in the same cycle as a bus error returns the old descriptor, captures the new one and leaves capture locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_evt_i | input | 6 | One-cycle error condition pulses from the protocol engine |
| err_code_i | input | 8 | Bus error descriptor, valid with `cond_evt_i[3]` |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects at address 3) |
| reg_addr_i | input | 2 | Register address: 0 status, 1 enable, 2 interrupt flag, 3 capture |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Summary frame error interrupt |

## Verification
The bench first drives directed sequences. Each isolates one rule: an enabled versus a disabled event, a flag clear attempted while an enabled cause is still pending versus after it has been cleared, a write aimed at the bus error bit versus a read of the capture register, and event and clear colliding in one cycle. A read of the capture register that coincides with a new bus error separates correct re-arm ordering from a capture that is lost or left unlocked. A long stretch of random events, writes and reads then runs against a behavioural model compared on every clock. That stretch exposes any interaction between the enable changes, the pending-cause guard and the capture lock that the directed cases miss.

// File: rtl/fei_pkg.sv
// Shared constants and register address map for the frame error
// interrupt controller. Assumes a byte-wide register port.
package fei_pkg;
    localparam int FEI_NUM_COND = 6;   // number of error conditions
    localparam int FEI_BERR_IDX = 3;   // status position of the bus error
    localparam int FEI_FLAG_IDX = 4;   // summary flag position in the flag register
    localparam int FEI_CODE_W   = 8;   // captured descriptor width
    localparam int FEI_DATA_W   = 8;   // register port width

    typedef enum logic [1:0] {
        ADDR_STATUS  = 2'd0,
        ADDR_ENABLE  = 2'd1,
        ADDR_IRQFLAG = 2'd2,
        ADDR_CAPTURE = 2'd3
    } fei_addr_e;
endpackage

// File: rtl/fei_status.sv
// Sticky status bits and the enable register.
// Each status bit is set by its hardware event pulse. The bus error bit is
// cleared only by a capture-register read; every other bit is cleared by
// a write of 1. A hardware set wins over a same-cycle clear.
// Assumes event pulses are synchronous to clk.
module fei_status #(
    parameter int NUM_COND = 6,
    parameter int BERR_IDX = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_COND-1:0] cond_evt,
    input  logic                st_wr,
    input  logic                en_wr,
    input  logic [NUM_COND-1:0] wdata,
    input  logic                cap_rd,
    output logic [NUM_COND-1:0] status,
    output logic [NUM_COND-1:0] enable
);
    // Enable register: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable <= '0;
        else if (en_wr) enable <= wdata;
    end

    for (genvar i = 0; i < NUM_COND; i++) begin : g_bit
        logic clr;
        if (i == BERR_IDX) begin : g_berr
            // Bus error bit: cleared by reading the capture register.
            assign clr = cap_rd;
            a_r6_fall_on_read: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(status[i]) |-> $past(cap_rd));
        end else begin : g_w1c
            // Other bits: write-1-to-clear.
            assign clr = st_wr && wdata[i];
            a_r5_fall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(status[i]) |-> $past(st_wr && wdata[i]));
        end

        // Status bit: set by event, else cleared by its own clear rule.
        always_ff @(posedge clk) begin
            if (!rst_n)           status[i] <= 1'b0;
            else if (cond_evt[i]) status[i] <= 1'b1;
            else if (clr)         status[i] <= 1'b0;
        end

        a_r2_rise_from_event: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[i]) |-> $past(cond_evt[i]));
        a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            cond_evt[i] |=> status[i]);
    end
endmodule

// File: rtl/fei_summary.sv
// Summary frame error interrupt flag.
// Set when any event arrives on an enabled condition. A software clear
// request succeeds only when no enabled status bit is pending. Set wins
// over a same-cycle clear. Assumes status/enable come from fei_status.
module fei_summary #(
    parameter int NUM_COND = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_COND-1:0] cond_evt,
    input  logic [NUM_COND-1:0] enable,
    input  logic [NUM_COND-1:0] status,
    input  logic                clr_req,
    output logic                flag
);
    logic set_hit;
    logic pending;

    // Qualify events and pending causes with their enables.
    always_comb begin
        set_hit = |(cond_evt & enable);
        pending = |(status & enable);
    end

    // Flag register: set has priority, clear is guarded by pending causes.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag <= 1'b0;
        else if (set_hit)            flag <= 1'b1;
        else if (clr_req && !pending) flag <= 1'b0;
    end

    a_r3_flag_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(|(cond_evt & enable)));
    a_r4_flag_fall_guard: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr_req && ((status & enable) == '0)));
    a_r4_pending_blocks_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ((status & enable) != '0)) |=> flag);
endmodule

// File: rtl/fei_capture.sv
// Bus error descriptor capture with read-to-rearm lock.
// The descriptor is taken when a bus error arrives while armed; it then
// locks. A read of the capture register re-arms it, unless a bus error
// arrives in that same cycle, in which case the new code is taken and
// the lock stays. Assumes code_i is valid with berr_evt.
module fei_capture #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              berr_evt,
    input  logic [CODE_W-1:0] code_i,
    input  logic              cap_rd,
    output logic [CODE_W-1:0] code,
    output logic              locked
);
    logic take;

    // Capture is allowed when armed or when being re-armed this cycle.
    always_comb take = berr_evt && (!locked || cap_rd);

    // Descriptor and lock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code   <= '0;
            locked <= 1'b0;
        end else if (take) begin
            code   <= code_i;
            locked <= 1'b1;
        end else if (cap_rd) begin
            locked <= 1'b0;
        end
    end

    a_r8_hold_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !cap_rd) |=> $stable(code));
    a_r7_take_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_evt && !locked) |=> (code == $past(code_i)));
    a_r10_read_and_error: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_evt && cap_rd) |=> (locked && code == $past(code_i)));
    a_r6_read_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_rd && !berr_evt) |=> !locked);
endmodule

// File: rtl/frame_err_irq.sv
// Frame error interrupt controller top: address decode, read mux and
// the three state blocks. Reads are combinational from reg_addr_i; only
// a read strobe at the capture address has a side effect.
// Assumes CODE_W and NUM_COND do not exceed DATA_W.
module frame_err_irq
    import fei_pkg::*;
#(
    parameter int NUM_COND = FEI_NUM_COND,
    parameter int BERR_IDX = FEI_BERR_IDX,
    parameter int FLAG_IDX = FEI_FLAG_IDX,
    parameter int CODE_W   = FEI_CODE_W,
    parameter int DATA_W   = FEI_DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_COND-1:0] cond_evt_i,
    input  logic [CODE_W-1:0]   err_code_i,
    input  logic                reg_wr_i,
    input  logic                reg_rd_i,
    input  logic [1:0]          reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                irq_o
);
    logic                st_wr, en_wr, cap_rd, clr_req;
    logic [NUM_COND-1:0] status, enable;
    logic [CODE_W-1:0]   code;
    logic                locked;
    logic                flag;
    logic                wdata_unused;

    // Register access decode.
    always_comb begin
        st_wr   = reg_wr_i && (reg_addr_i == ADDR_STATUS);
        en_wr   = reg_wr_i && (reg_addr_i == ADDR_ENABLE);
        clr_req = reg_wr_i && (reg_addr_i == ADDR_IRQFLAG) && reg_wdata_i[FLAG_IDX];
        cap_rd  = reg_rd_i && (reg_addr_i == ADDR_CAPTURE);
    end

    assign wdata_unused = ^reg_wdata_i;

    fei_status #(.NUM_COND(NUM_COND), .BERR_IDX(BERR_IDX)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_evt (cond_evt_i),
        .st_wr    (st_wr),
        .en_wr    (en_wr),
        .wdata    (reg_wdata_i[NUM_COND-1:0]),
        .cap_rd   (cap_rd),
        .status   (status),
        .enable   (enable)
    );

    fei_summary #(.NUM_COND(NUM_COND)) u_summary (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_evt (cond_evt_i),
        .enable   (enable),
        .status   (status),
        .clr_req  (clr_req),
        .flag     (flag)
    );

    fei_capture #(.CODE_W(CODE_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .berr_evt (cond_evt_i[BERR_IDX]),
        .code_i   (err_code_i),
        .cap_rd   (cap_rd),
        .code     (code),
        .locked   (locked)
    );

    // Read mux: zero-extended register views.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_STATUS:  reg_rdata_o[NUM_COND-1:0] = status;
            ADDR_ENABLE:  reg_rdata_o[NUM_COND-1:0] = enable;
            ADDR_IRQFLAG: reg_rdata_o[FLAG_IDX]     = flag;
            default:      reg_rdata_o[CODE_W-1:0]   = code;
        endcase
    end

    assign irq_o = flag;

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && status == '0 && enable == '0 && !locked));
    a_r6_status_tracks_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> status[BERR_IDX]);
endmodule

// File: tb/frame_err_irq_test.sv
`timescale 1ns/1ps
module frame_err_irq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ev = '0;
    logic [7:0] code = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit chk_on = 1'b0;

    // behavioural reference state
    logic [5:0] m_st, m_en;
    logic       m_flag, m_lock;
    logic [7:0] m_cap;

    frame_err_irq uut (
        .clk(clk), .rst_n(rst_n), .cond_evt_i(ev), .err_code_i(code),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model update, one step per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = '0; m_en = '0; m_flag = 1'b0; m_lock = 1'b0; m_cap = '0;
        end else begin
            bit cr, hit, pend;
            logic [5:0] nst;
            cr   = rd && addr == 2'd3;
            hit  = |(ev & m_en);
            pend = |(m_st & m_en);
            nst  = m_st;
            if (wr && addr == 2'd0) nst = nst & ~(wdata[5:0] & 6'b110111);
            if (cr) nst[3] = 1'b0;
            nst = nst | ev;
            if (hit) m_flag = 1'b1;
            else if (wr && addr == 2'd2 && wdata[4] && !pend) m_flag = 1'b0;
            if (ev[3] && (!m_lock || cr)) begin m_cap = code; m_lock = 1'b1; end
            else if (cr) m_lock = 1'b0;
            if (wr && addr == 2'd1) m_en = wdata[5:0];
            m_st = nst;
        end
    end

    function automatic logic [7:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0: return {2'b00, m_st};
            2'd1: return {2'b00, m_en};
            2'd2: return {3'b000, m_flag, 4'b0000};
            default: return m_cap;
        endcase
    endfunction

    function automatic string addr_tag(input logic [1:0] a);
        case (a)
            2'd0: return "R2/R5/R6 status model";
            2'd1: return "R2 enable model";
            2'd2: return "R4 flag register model";
            default: return "R7/R8 capture model";
        endcase
    endfunction

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            chk("R3 irq model", {7'b0, irq}, {7'b0, m_flag});
            chk(addr_tag(addr), rdata, model_rd(addr));
        end
    end

    task automatic apply(input logic [5:0] e, input logic [7:0] c, input logic w,
                         input logic r, input logic [1:0] a, input logic [7:0] d);
        ev = e; code = c; wr = w; rd = r; addr = a; wdata = d;
        @(posedge clk); #1;
        ev = '0; wr = 1'b0; rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        @(negedge clk); #1;
        chk(tag, rdata, exp);
    endtask

    task automatic peek_irq(input logic exp, input string tag);
        @(negedge clk); #1;
        chk(tag, {7'b0, irq}, {7'b0, exp});
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired before completion (all requirements)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_on = 1'b1;
        // R1 reset state
        peek(2'd0, 8'h00, "R1 status after reset");
        peek(2'd1, 8'h00, "R1 enable after reset");
        peek(2'd2, 8'h00, "R1 flag after reset");
        peek(2'd3, 8'h00, "R1 capture after reset");
        peek_irq(1'b0, "R1 irq after reset");

        // enable bus error, then a bus error with descriptor 0x63
        apply(6'h00, 8'h00, 1, 0, 2'd1, 8'h08);
        peek(2'd1, 8'h08, "R2 enable readback");
        apply(6'h08, 8'h63, 0, 0, 2'd0, 8'h00);
        peek(2'd0, 8'h08, "R2 bus error sets status bit 3");
        peek(2'd3, 8'h63, "R7 descriptor captured");
        peek(2'd2, 8'h10, "R3 summary flag at bit 4");
        peek_irq(1'b1, "R3 irq raised by enabled event");

        // second bus error while locked
        apply(6'h08, 8'hA5, 0, 0, 2'd0, 8'h00);
        peek(2'd3, 8'h63, "R8 locked capture holds old code");
        peek(2'd0, 8'h08, "R8 status still set");

        // flag clear while cause pending, write to bit 3
        apply(6'h00, 8'h00, 1, 0, 2'd2, 8'h10);
        peek_irq(1'b1, "R4 clear ignored while enabled cause pending");
        apply(6'h00, 8'h00, 1, 0, 2'd0, 8'h08);
        peek(2'd0, 8'h08, "R5 write cannot clear bus error bit");

        // read capture clears bit 3, then flag clear succeeds
        apply(6'h00, 8'h00, 0, 1, 2'd3, 8'h00);
        peek(2'd0, 8'h00, "R6 capture read clears bus error bit");
        apply(6'h00, 8'h00, 1, 0, 2'd2, 8'h10);
        peek_irq(1'b0, "R4 clear accepted after causes cleared");

        // re-armed capture takes a new code
        apply(6'h08, 8'hA5, 0, 0, 2'd0, 8'h00);
        peek(2'd3, 8'hA5, "R7 re-armed capture takes new code");
        apply(6'h00, 8'h00, 0, 1, 2'd3, 8'h00);
        apply(6'h00, 8'h00, 1, 0, 2'd2, 8'h10);
        peek_irq(1'b0, "R4 flag cleared again");

        // disabled condition
        apply(6'h02, 8'h00, 0, 0, 2'd0, 8'h00);
        peek(2'd0, 8'h02, "R3 disabled event sets status only");
        peek_irq(1'b0, "R3 disabled event leaves irq low");
        apply(6'h00, 8'h00, 1, 0, 2'd0, 8'h02);
        peek(2'd0, 8'h00, "R5 write-1 clears non-bus-error bit");

        // collisions: set beats clear
        apply(6'h04, 8'h00, 1, 0, 2'd0, 8'h04);
        peek(2'd0, 8'h04, "R9 event beats status clear");
        apply(6'h00, 8'h00, 1, 0, 2'd1, 8'h01);
        apply(6'h01, 8'h00, 1, 0, 2'd2, 8'h10);
        peek_irq(1'b1, "R9 event beats flag clear");
        apply(6'h00, 8'h00, 1, 0, 2'd0, 8'h05);
        apply(6'h00, 8'h00, 1, 0, 2'd2, 8'h10);
        peek_irq(1'b0, "R4 flag cleared after collision test");

        // read of capture coincident with a bus error
        apply(6'h00, 8'h00, 1, 0, 2'd1, 8'h08);
        apply(6'h08, 8'h11, 0, 0, 2'd0, 8'h00);
        ev = 6'h08; code = 8'hC7; rd = 1'b1; addr = 2'd3;
        @(negedge clk); #1;
        chk("R10 read returns old descriptor", rdata, 8'h11);
        @(posedge clk); #1;
        ev = '0; rd = 1'b0;
        peek(2'd3, 8'hC7, "R10 new descriptor captured during read");
        apply(6'h08, 8'h22, 0, 0, 2'd0, 8'h00);
        peek(2'd3, 8'hC7, "R10 capture stays locked");
        peek(2'd0, 8'h08, "R10 bus error status set");

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            logic [5:0]  e;
            r = $urandom;
            e = (r[2:0] == 3'd0) ? 6'(r[17:12]) : 6'h00;
            apply(e, r[31:24], r[5:4] == 2'd0, r[7:6] == 2'd0, r[9:8], {r[23:18], r[11:10]});
        end

        chk_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule